// File: doc/BRIEF.md
# Port-to-Memory FIFO Flush Controller

This block buffers bytes that arrive from a parallel peripheral port on their way to system memory. It decides when those bytes must leave as a burst toward a simple memory-write master. It holds up to 64 bytes. It normally emits a fixed-size burst once enough bytes have gathered. A set of consistency events forces everything currently held to be flushed at once, so that software sees a predictable memory image. These events are CPU register writes, a new pending interrupt, a reset or invalidate command, and an address reload. CPU register accesses themselves never pass through the buffer.

Bytes enter on a valid/ready stream. A byte is taken on any clock where `in_valid` and `in_ready` are both high. The producer may drop `in_valid` at any time. `in_ready` is low while a burst is in flight, while an invalidate is pending, and when the buffer is full. Bytes leave on a second valid/ready stream. A burst is `out_count` beats long, with `out_last` on the final beat. While `out_valid` is high and `out_ready` is low, the data, count and address are held unchanged. The memory address register steps forward by the size of each completed burst.

Top module: `pport_drain_ctrl`

## Requirements
- R1: Bytes leave on `out_data` in exactly the order they were accepted on `in_data`, and the held byte count `fifo_level` never exceeds the depth (64).
- R2: With no forced flush pending, a burst starts once `fifo_level` reaches the size chosen by `burst_sel`: 2'b00 gives 4, 2'b01 gives 16, 2'b10 gives 32 and 2'b11 gives 4. The burst carries exactly that many bytes.
- R3: A forced flush sends every byte held when it starts, with `out_count` equal to that number. A forced flush with nothing held produces no output beat. `out_count` is never zero while `out_valid` is high.
- R4: A pulse on `reg_wr` forces a flush for every `reg_sel` value except 3'd4 (test register). A write with `reg_sel` = 3'd1 (address register) forces no flush while `diag` is high.
- R5: A rising edge of `irq_pend` or of `csr_reset` forces a flush. A level that stays high forces nothing more.
- R6: A rising edge of `csr_inval` forces a flush of the held bytes, then empties the buffer. `in_ready` stays low from the cycle after the edge until this completes.
- R7: A pulse on `addr_reload` captures `next_addr`. When `diag` is low, the bytes held at that moment are first flushed at the old address, and only then is the new address installed. When `diag` is high, the address is installed without a flush.
- R8: `out_addr` gives the burst's memory address. After the last beat of a burst it advances by that burst's `out_count`.
- R9: `in_ready` is low whenever a burst is in flight. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_count` and `out_addr` hold their values.
- R10: Flush events that arrive while a burst is in flight are remembered. They are served, as a separate flush of the bytes then held, after that burst ends.
- R11: After reset `in_ready` is high, `out_valid` and `drain_busy` are low, `fifo_level` is 0 and `out_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Port byte offered |
| in_ready | output | 1 | Block can take a port byte |
| in_data | input | 8 | Port byte |
| out_valid | output | 1 | Burst beat available |
| out_ready | input | 1 | Memory master takes the beat |
| out_data | output | 8 | Burst beat data |
| out_last | output | 1 | Final beat of the burst |
| out_count | output | 7 | Bytes in the current burst |
| out_addr | output | 32 | Memory address of the current burst |
| reg_wr | input | 1 | CPU register write strobe |
| reg_sel | input | 3 | Register being written (1 address, 4 test, others ordinary) |
| diag | input | 1 | Diagnostic mode, masks address-related triggers |
| burst_sel | input | 2 | Burst size code |
| irq_pend | input | 1 | Interrupt pending status |
| csr_reset | input | 1 | Channel reset command bit |
| csr_inval | input | 1 | Invalidate command bit |
| addr_reload | input | 1 | Load the address register from `next_addr` |
| next_addr | input | 32 | Address to load on reload |
| fifo_level | output | 7 | Bytes currently held |
| drain_busy | output | 1 | Burst in flight |

## Verification
The bench uses the default parameters: a 64-byte buffer and a 32-bit address. With these values all four burst-size codes can be reached, and so can forced flushes of up to about 33 bytes, and address runs that never wrap. The random phase changes the burst size, the register writes and the interrupt edges in the middle of a stream, while the output side applies back-pressure. Under that mix, burst boundaries land in many different places, and flush events arrive while a burst is still open.

// File: rtl/pport_drain_pkg.sv
package pport_drain_pkg;

  typedef enum logic [2:0] {
    SEL_CSR   = 3'd0,
    SEL_ADDR  = 3'd1,
    SEL_COUNT = 3'd2,
    SEL_NEXT  = 3'd3,
    SEL_TEST  = 3'd4
  } reg_sel_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_BURST = 1'b1
  } seq_state_e;

  function automatic int unsigned burst_bytes(input logic [1:0] code);
    case (code)
      2'b01:   return 16;
      2'b10:   return 32;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/pport_byte_fifo.sv
module pport_byte_fifo #(
  parameter int DEPTH = 64,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [7:0]       wdata,
  input  logic             pop,
  output logic [7:0]       rdata,
  output logic [LVL_W-1:0] level
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [7:0]     mem [DEPTH];
  logic [PTR_W:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr[PTR_W-1:0]] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
    end
  end

  assign rdata = mem[rd_ptr[PTR_W-1:0]];
  assign level = LVL_W'(wr_ptr - rd_ptr);
endmodule

// File: rtl/pport_drain_trig.sv
module pport_drain_trig
  import pport_drain_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_sel,
  input  logic       diag,
  input  logic       irq_pend,
  input  logic       csr_reset,
  input  logic       csr_inval,
  input  logic       addr_reload,
  output logic       force_evt,
  output logic       inval_evt,
  output logic       reload_evt
);
  logic irq_q, rst_q, inval_q;
  logic irq_rise, rst_rise, wr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      rst_q   <= 1'b0;
      inval_q <= 1'b0;
    end else begin
      irq_q   <= irq_pend;
      rst_q   <= csr_reset;
      inval_q <= csr_inval;
    end
  end

  always_comb begin
    irq_rise  = irq_pend && !irq_q;
    rst_rise  = csr_reset && !rst_q;
    inval_evt = csr_inval && !inval_q;
    wr_hit    = reg_wr && (reg_sel != 3'(SEL_TEST))
                && !((reg_sel == 3'(SEL_ADDR)) && diag);
    reload_evt = addr_reload;
    force_evt  = irq_rise || rst_rise || inval_evt || wr_hit
                 || (addr_reload && !diag);
  end
endmodule

// File: rtl/pport_drain_seq.sv
module pport_drain_seq
  import pport_drain_pkg::*;
#(
  parameter int LVL_W  = 7,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              force_evt,
  input  logic              inval_evt,
  input  logic              reload_evt,
  input  logic [ADDR_W-1:0] next_addr,
  input  logic [1:0]        burst_sel,
  input  logic [LVL_W-1:0]  level,
  input  logic              out_ready,
  output logic              busy,
  output logic              hold_in,
  output logic              fifo_clr,
  output logic              pop,
  output logic              out_valid,
  output logic              out_last,
  output logic [LVL_W-1:0]  out_count,
  output logic [ADDR_W-1:0] out_addr
);
  seq_state_e        state;
  logic [LVL_W-1:0]  rem, cnt, thr;
  logic [ADDR_W-1:0] addr, reload_val;
  logic              force_pend, inval_pend, reload_pend;
  logic              start_force, finalize, start_thr, done;

  always_comb begin
    busy        = (state == ST_BURST);
    thr         = LVL_W'(burst_bytes(burst_sel));
    start_force = !busy && force_pend && (level != '0);
    finalize    = !busy && !start_force && (force_pend || inval_pend || reload_pend);
    start_thr   = !busy && !start_force && !finalize && (level >= thr);
    pop         = busy && out_ready;
    done        = pop && (rem == LVL_W'(1));
    fifo_clr    = finalize && inval_pend;
    hold_in     = inval_pend;
    out_valid   = busy;
    out_last    = busy && (rem == LVL_W'(1));
    out_count   = cnt;
    out_addr    = addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      rem         <= '0;
      cnt         <= '0;
      addr        <= '0;
      reload_val  <= '0;
      force_pend  <= 1'b0;
      inval_pend  <= 1'b0;
      reload_pend <= 1'b0;
    end else begin
      force_pend  <= (force_pend && !(start_force || finalize)) || force_evt;
      inval_pend  <= (inval_pend && !finalize) || inval_evt;
      reload_pend <= (reload_pend && !finalize) || reload_evt;
      if (reload_evt) reload_val <= next_addr;

      if (start_force) begin
        state <= ST_BURST;
        cnt   <= level;
        rem   <= level;
      end else if (start_thr) begin
        state <= ST_BURST;
        cnt   <= thr;
        rem   <= thr;
      end else if (finalize && reload_pend) begin
        addr <= reload_val;
      end

      if (pop) begin
        rem <= rem - 1'b1;
        if (done) begin
          state <= ST_IDLE;
          addr  <= addr + ADDR_W'(cnt);
        end
      end
    end
  end
endmodule

// File: rtl/pport_drain_ctrl.sv
module pport_drain_ctrl #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_last,
  output logic [LVL_W-1:0]  out_count,
  output logic [ADDR_W-1:0] out_addr,
  input  logic              reg_wr,
  input  logic [2:0]        reg_sel,
  input  logic              diag,
  input  logic [1:0]        burst_sel,
  input  logic              irq_pend,
  input  logic              csr_reset,
  input  logic              csr_inval,
  input  logic              addr_reload,
  input  logic [ADDR_W-1:0] next_addr,
  output logic [LVL_W-1:0]  fifo_level,
  output logic              drain_busy
);
  logic force_evt, inval_evt, reload_evt;
  logic busy, hold_in, fifo_clr, pop, push;

  assign in_ready   = !busy && !hold_in && (fifo_level < LVL_W'(DEPTH));
  assign push       = in_valid && in_ready;
  assign drain_busy = busy;

  pport_drain_trig u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .diag       (diag),
    .irq_pend   (irq_pend),
    .csr_reset  (csr_reset),
    .csr_inval  (csr_inval),
    .addr_reload(addr_reload),
    .force_evt  (force_evt),
    .inval_evt  (inval_evt),
    .reload_evt (reload_evt)
  );

  pport_byte_fifo #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_fifo (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (fifo_clr),
    .push (push),
    .wdata(in_data),
    .pop  (pop),
    .rdata(out_data),
    .level(fifo_level)
  );

  pport_drain_seq #(.LVL_W(LVL_W), .ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .force_evt (force_evt),
    .inval_evt (inval_evt),
    .reload_evt(reload_evt),
    .next_addr (next_addr),
    .burst_sel (burst_sel),
    .level     (fifo_level),
    .out_ready (out_ready),
    .busy      (busy),
    .hold_in   (hold_in),
    .fifo_clr  (fifo_clr),
    .pop       (pop),
    .out_valid (out_valid),
    .out_last  (out_last),
    .out_count (out_count),
    .out_addr  (out_addr)
  );
endmodule

// File: rtl/pport_drain_chk.sv
module pport_drain_chk #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        out_data,
  input logic              out_last,
  input logic [LVL_W-1:0]  out_count,
  input logic [ADDR_W-1:0] out_addr,
  input logic [LVL_W-1:0]  fifo_level,
  input logic              drain_busy
);
  p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LVL_W'(DEPTH));

  p_pop_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (fifo_level == $past(fifo_level) - 1'b1));

  p_count_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_count != '0) && (out_count <= LVL_W'(DEPTH)));

  p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last)
      |=> (out_addr == $past(out_addr) + ADDR_W'($past(out_count))));

  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !drain_busy);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data)
      && $stable(out_count) && $stable(out_addr));
endmodule

bind pport_drain_ctrl pport_drain_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last),
  .out_count (out_count),
  .out_addr  (out_addr),
  .fifo_level(fifo_level),
  .drain_busy(drain_busy)
);

// File: tb/tb_pport_drain_ctrl.sv
module tb_pport_drain_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_ready;
  logic [7:0] in_data = '0;
  logic       out_valid, out_ready = 1'b1, out_last;
  logic [7:0] out_data;
  logic [6:0] out_count, fifo_level;
  logic [31:0] out_addr, next_addr = '0;
  logic       reg_wr = 1'b0, diag = 1'b0, irq_pend = 1'b0;
  logic       csr_reset = 1'b0, csr_inval = 1'b0, addr_reload = 1'b0;
  logic [2:0] reg_sel = '0;
  logic [1:0] burst_sel = '0;
  logic       drain_busy;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0]  sent [$];
  int          bcnt [$];
  logic [31:0] baddr [$];
  int          beat_n = 0, cur_cnt = 0;
  logic [31:0] cur_addr = '0, exp_addr = '0;
  int unsigned seed_v;

  always #(CLK_PERIOD/2) clk = ~clk;

  pport_drain_ctrl dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .out_count(out_count),
    .out_addr(out_addr), .reg_wr(reg_wr), .reg_sel(reg_sel), .diag(diag),
    .burst_sel(burst_sel), .irq_pend(irq_pend), .csr_reset(csr_reset),
    .csr_inval(csr_inval), .addr_reload(addr_reload), .next_addr(next_addr),
    .fifo_level(fifo_level), .drain_busy(drain_busy)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard: every beat against the byte order seen at the input
  always @(posedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready) begin
        if (beat_n == 0) begin
          cur_cnt  = int'(out_count);
          cur_addr = out_addr;
        end
        if (sent.size() == 0) chk(0, "R1 beat with no byte pending", out_data, 0);
        else begin
          logic [7:0] e;
          e = sent.pop_front();
          chk(out_data == e, "R1 byte order", out_data, e);
        end
        beat_n++;
        if (out_last) begin
          chk(beat_n == cur_cnt, "R3 beats match out_count", beat_n, cur_cnt);
          bcnt.push_back(cur_cnt);
          baddr.push_back(cur_addr);
          beat_n = 0;
        end
      end
      if (in_valid && in_ready) sent.push_back(in_data);
    end
  end

  task automatic push(input logic [7:0] b);
    in_data  = b;
    in_valid = 1'b1;
    @(posedge clk);
    while (!in_ready) @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic push_n(input int n);
    for (int i = 0; i < n; i++) push(8'($urandom));
  endtask

  task automatic wr(input logic [2:0] sel);
    reg_sel = sel;
    reg_wr  = 1'b1;
    @(negedge clk);
    reg_wr  = 1'b0;
  endtask

  task automatic settle();
    for (int k = 0; k < 3; k++) begin
      repeat (4) @(negedge clk);
      while (drain_busy) @(negedge clk);
    end
  endtask

  task automatic expect_burst(input int cnt, input string tag);
    if (bcnt.size() == 0) chk(0, tag, 0, cnt);
    else begin
      int c;
      logic [31:0] a;
      c = bcnt.pop_front();
      a = baddr.pop_front();
      chk(c == cnt, tag, c, cnt);
      chk(a == exp_addr, "R8 burst address", a, exp_addr);
      exp_addr = exp_addr + 32'(cnt);
    end
  endtask

  task automatic expect_none(input string tag);
    chk(bcnt.size() == 0, tag, bcnt.size(), 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R9 watchdog: got hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    seed_v = $urandom(32'h1F2E3D4C);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(in_ready == 1'b1, "R11 in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R11 out_valid after reset", out_valid, 0);
    chk(drain_busy == 1'b0, "R11 busy after reset", drain_busy, 0);
    chk(fifo_level == 0, "R11 level after reset", fifo_level, 0);
    chk(out_addr == 0, "R11 address after reset", out_addr, 0);

    // R2 thresholds for each code
    burst_sel = 2'b00;
    push_n(3); settle();
    expect_none("R2 below 4 no burst");
    chk(fifo_level == 3, "R2 level held", fifo_level, 3);
    push_n(1); settle();
    expect_burst(4, "R2 code 00 burst 4");
    burst_sel = 2'b01; push_n(16); settle();
    expect_burst(16, "R2 code 01 burst 16");
    burst_sel = 2'b10; push_n(32); settle();
    expect_burst(32, "R2 code 10 burst 32");
    burst_sel = 2'b11; push_n(4); settle();
    expect_burst(4, "R2 code 11 burst 4");

    // R4 register writes
    burst_sel = 2'b10;
    push_n(5); wr(3'd4); settle();
    expect_none("R4 test register write ignored");
    chk(fifo_level == 5, "R4 level after test write", fifo_level, 5);
    wr(3'd2); settle();
    expect_burst(5, "R3 R4 forced flush count");
    push_n(2); diag = 1'b1; wr(3'd1); settle();
    expect_none("R4 address write masked by diag");
    chk(fifo_level == 2, "R4 level after masked write", fifo_level, 2);
    diag = 1'b0; wr(3'd1); settle();
    expect_burst(2, "R4 address write flushes");

    // R5 edges
    push_n(3); irq_pend = 1'b1; settle();
    expect_burst(3, "R5 interrupt edge flush");
    push_n(2); settle();
    expect_none("R5 steady interrupt no flush");
    irq_pend = 1'b0;
    csr_reset = 1'b1; @(negedge clk); csr_reset = 1'b0; settle();
    expect_burst(2, "R5 reset bit flush");

    // R3 empty flush suppressed
    wr(3'd0); settle();
    expect_none("R3 zero-byte flush suppressed");

    // R6 invalidate
    push_n(6);
    csr_inval = 1'b1; @(negedge clk); csr_inval = 1'b0;
    chk(in_ready == 1'b0, "R6 in_ready low after invalidate", in_ready, 0);
    settle();
    expect_burst(6, "R6 invalidate flushes first");
    chk(fifo_level == 0, "R6 buffer empty after invalidate", fifo_level, 0);

    // R7 reload
    push_n(3); next_addr = 32'h100;
    addr_reload = 1'b1; @(negedge clk); addr_reload = 1'b0; settle();
    expect_burst(3, "R7 reload flushes at old address");
    exp_addr = 32'h100;
    burst_sel = 2'b00; push_n(4); settle();
    expect_burst(4, "R7 new address after reload");
    push_n(2); diag = 1'b1; next_addr = 32'h200;
    addr_reload = 1'b1; @(negedge clk); addr_reload = 1'b0; settle();
    expect_none("R7 diag reload no flush");
    diag = 1'b0; exp_addr = 32'h200;
    push_n(2); settle();
    expect_burst(4, "R7 diag reload installs address");

    // R9 back-pressure, R10 latched event
    burst_sel = 2'b01; push_n(5);
    out_ready = 1'b0; burst_sel = 2'b00;
    repeat (2) @(negedge clk);
    chk(drain_busy == 1'b1, "R9 burst in flight", drain_busy, 1);
    chk(in_ready == 1'b0, "R9 in_ready low in burst", in_ready, 0);
    begin
      logic [7:0] d;
      d = out_data;
      repeat (3) @(negedge clk);
      chk(out_data == d, "R9 data held under stall", out_data, d);
      chk(out_count == 4, "R9 count held under stall", out_count, 4);
    end
    wr(3'd0);
    out_ready = 1'b1; settle();
    expect_burst(4, "R10 threshold burst before latched flush");
    expect_burst(1, "R10 latched flush after burst");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      in_valid  = ($urandom % 10) < 6;
      in_data   = 8'($urandom);
      out_ready = ($urandom % 10) < 7;
      reg_wr    = ($urandom % 50) == 0;
      reg_sel   = 3'($urandom % 5);
      if (($urandom % 100) == 0) burst_sel = 2'($urandom);
      if (($urandom % 80) == 0) irq_pend = !irq_pend;
    end
    @(negedge clk);
    in_valid = 1'b0; reg_wr = 1'b0; irq_pend = 1'b0; out_ready = 1'b1;
    settle();
    wr(3'd0); settle();
    chk(sent.size() == 0, "R3 every byte flushed", sent.size(), 0);
    chk(fifo_level == 0, "R3 level zero at end", fifo_level, 0);
    while (bcnt.size() > 0) begin
      int c;
      logic [31:0] a;
      c = bcnt.pop_front();
      a = baddr.pop_front();
      chk(c > 0 && c <= DEPTH, "R3 random burst size range", c, DEPTH);
      chk(a == exp_addr, "R8 random address continuity", a, exp_addr);
      exp_addr = exp_addr + 32'(c);
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule